// File: doc/BRIEF.md
# Polyphase Rational Resampler

This block changes the sample rate of one real, signed fixed-point stream by the ratio L/M. Its output equals what an interpolate-by-L, FIR-filter, decimate-by-M chain would produce. The chain is never built literally. A phase counter picks which polyphase branch of the coefficient set applies to each output, and only the outputs that survive decimation are computed. No zero-stuffed samples are ever multiplied.

Samples enter through a valid/ready handshake. A sample is taken on a clock edge where `valid_i` and `ready_o` are both high. Results leave through a one-entry holding register that releases its content only on a cycle where the downstream `req_i` is high. While a result waits in that register, the input side is stalled, so no computed sample is ever overwritten. The coefficients are a compile-time parameter. Coefficient 0 multiplies the newest sample, and each coefficient carries CF fractional bits.

Top module: `rcv_resampler`

## Requirements
- R1: After reset, `valid_o` is low and `ready_o` is high. Every delay-line slot holds zero, so the first output depends only on the first accepted sample.
- R2: Output n equals the sum over i of h[k+i·L]·x[m−i], where m = floor(n·M/L) and k = (n·M) mod L. Here h[j] is coefficient j, with h[j] = 0 for j ≥ N, and x[j] is the j-th accepted sample, with x[j] = 0 for j < 0.
- R3: Each output is bits CF to CF+DW−1 of the full-precision sum of R2. This is floor rounding followed by wrap-around. For example, input −1 against a positive h[0] gives −1, not 0.
- R4: `valid_o` is high only on cycles where `req_i` is high and a computed sample is pending. With no accepted input, `valid_o` stays low.
- R5: While a sample is held and `req_i` is low, `ready_o` is low and the held value is kept unchanged. Every computed sample leaves exactly once and in order, so P accepted inputs yield floor((L·P−1)/M)+1 outputs.
- R6: `valid_i` on a cycle where `ready_o` is low has no effect on any later output.
- R7: When L ≥ M and `req_i` is held high, presenting a sample whenever `ready_o` is high makes `valid_o` high on every cycle between the first and the last output.
- R8: With `req_i` high and the block idle after reset, a sample accepted on cycle C gives its first output with `valid_o` high on cycle C+2.
- R9: When M > L, the sequencer takes several inputs between outputs. The output values and count still follow R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | DW | Signed input sample |
| ready_o | output | 1 | Block accepts `data_i` at this edge when `valid_i` is high |
| req_i | input | 1 | Downstream request for the pending output |
| valid_o | output | 1 | `data_o` carries a new output sample |
| data_o | output | DW | Signed resampled output |

## Verification
The hardest state to reach from the ports is a held output, with the sequencer needing no new input, while a sample sits waiting on `data_i` that must not be taken. The bench reaches it by accepting one sample with `req_i` low. That sample is computed into the holding register while junk is driven with `valid_i` high. The bench then checks that `ready_o` stays low and that the junk never appears in the reference comparison. A second instance with M > L, plus a free-running toggle on `req_i` during streaming, covers the multi-input steps and the alternating hold-and-release pattern.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/rcv_phase_seq.sv
module rcv_phase_seq #(
  parameter int L  = 3,
  parameter int M  = 2,
  parameter int PW = 2,
  parameter int NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          accept_i,
  input  logic          stall_i,
  output logic [PW-1:0] phase_o,
  output logic          need_zero_o,
  output logic          ready_o
);
  localparam int SW = $clog2(L + M) + 1;

  logic [PW-1:0] phase_q;
  logic [NW-1:0] need_q;
  logic [SW-1:0] sum;
  logic [NW-1:0] consume;
  logic [PW-1:0] next_phase;

  assign sum        = SW'(phase_q) + SW'(M);
  assign consume    = NW'(sum / SW'(L));
  assign next_phase = PW'(sum % SW'(L));

  assign phase_o     = phase_q;
  assign need_zero_o = (need_q == '0);
  // take input when still short of samples, or when this output step uses one
  assign ready_o = ((need_q != '0) && !stall_i) || (fire_i && (consume != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      need_q  <= NW'(1);
    end else if (fire_i) begin
      phase_q <= next_phase;
      need_q  <= consume - NW'(accept_i);
    end else begin
      need_q  <= need_q - NW'(accept_i);
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q) < L); // R2
  AST_FIRE_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> need_q == '0); // R2
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !ready_o); // R5
endmodule

// File: rtl/rcv_tap_line.sv
module rcv_tap_line #(
  parameter int T  = 3,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic [DW-1:0]   din_i,
  output logic [T*DW-1:0] taps_o
);
  logic [T*DW-1:0] taps_q;

  generate
    if (T == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      taps_q <= '0;
        else if (shift_i) taps_q <= din_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      taps_q <= '0;
        else if (shift_i) taps_q <= {taps_q[(T-1)*DW-1:0], din_i};
      end
    end
  endgenerate

  assign taps_o = taps_q;

  AST_TAP_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_q[DW-1:0] == $past(din_i)); // R2
  AST_TAP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_q)); // R6
endmodule

// File: rtl/rcv_poly_mac.sv
module rcv_poly_mac #(
  parameter int L  = 3,
  parameter int T  = 3,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CF = 16,
  parameter int PW = 2,
  parameter logic [L*T*CW-1:0] PAD = '0
) (
  input  logic [PW-1:0]   phase_i,
  input  logic [T*DW-1:0] taps_i,
  output logic [DW-1:0]   y_o
);
  localparam int AW = DW + CW + $clog2(T + 1) + 1;

  logic signed [AW-1:0] acc;
  logic signed [CW-1:0] c;
  logic signed [DW-1:0] d;
  logic signed [AW-1:0] ce;
  logic signed [AW-1:0] de;

  always_comb begin
    acc = '0;
    c   = '0;
    d   = '0;
    ce  = '0;
    de  = '0;
    for (int i = 0; i < T; i++) begin
      c   = PAD[(int'(phase_i) + i*L)*CW +: CW];
      d   = taps_i[i*DW +: DW];
      ce  = AW'(c);
      de  = AW'(d);
      acc = acc + ce * de;
    end
  end

  // floor by dropping fraction bits, wrap by dropping the top
  assign y_o = acc[CF +: DW];
endmodule

// File: rtl/rcv_resampler.sv
module rcv_resampler #(
  parameter int L  = 3,
  parameter int M  = 2,
  parameter int N  = 7,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CF = 16,
  parameter logic [N*CW-1:0] COEFS = {16'd1200, 16'd4000, 16'd9000, 16'd12000,
                                      16'd9000, 16'd4000, 16'd1200}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          ready_o,
  input  logic          req_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  localparam int T  = rcv_pkg::cdiv(N, L);
  localparam int PW = (L > 1) ? $clog2(L) : 1;
  localparam int NW = $clog2((L - 1 + M) / L + 1) + 1;
  localparam logic [L*T*CW-1:0] PAD = (L*T*CW)'(COEFS);

  logic            hold_full_q;
  logic [DW-1:0]   hold_data_q;
  logic            need_zero;
  logic            fire;
  logic            accept;
  logic            pop;
  logic            stall;
  logic [PW-1:0]   phase;
  logic [T*DW-1:0] taps;
  logic [DW-1:0]   y;

  assign pop    = hold_full_q && req_i;
  assign stall  = hold_full_q && !req_i;
  assign fire   = need_zero && (!hold_full_q || req_i);
  assign accept = valid_i && ready_o;

  rcv_phase_seq #(.L(L), .M(M), .PW(PW), .NW(NW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .accept_i    (accept),
    .stall_i     (stall),
    .phase_o     (phase),
    .need_zero_o (need_zero),
    .ready_o     (ready_o)
  );

  rcv_tap_line #(.T(T), .DW(DW)) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .din_i   (data_i),
    .taps_o  (taps)
  );

  rcv_poly_mac #(.L(L), .T(T), .DW(DW), .CW(CW), .CF(CF), .PW(PW), .PAD(PAD)) u_mac (
    .phase_i (phase),
    .taps_i  (taps),
    .y_o     (y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
    end else if (fire) begin
      hold_full_q <= 1'b1;
      hold_data_q <= y;
    end else if (pop) begin
      hold_full_q <= 1'b0;
    end
  end

  assign valid_o = pop;
  assign data_o  = hold_data_q;

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i); // R4
  AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_full_q |-> !valid_o); // R4
  AST_HOLD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !req_i) |=> (hold_full_q && $stable(hold_data_q))); // R5
  AST_STALL_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !req_i) |-> !ready_o); // R5
endmodule

// File: tb/rcv_resampler_test.sv
module rcv_resampler_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic va = 1'b0, qa = 1'b0, vb = 1'b0, qb = 1'b0;
  logic [15:0] da = '0, db = '0;
  logic ra, voa, rb, vob;
  logic [15:0] doa, dob;
  logic toggle_en = 1'b0;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int xa[256], xb[256], oa[256];
  int nia = 0, nib = 0, noa = 0, nob = 0;
  int vcnt = 0, vfirst = 0, vlast = 0;
  int hc[7] = '{1200, 4000, 9000, 12000, 9000, 4000, 1200};

  always #(CLK_PERIOD/2) clk = ~clk;

  rcv_resampler uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(va), .data_i(da), .ready_o(ra),
    .req_i(qa), .valid_o(voa), .data_o(doa));

  rcv_resampler #(.L(2), .M(5)) uut_dec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vb), .data_i(db), .ready_o(rb),
    .req_i(qb), .valid_o(vob), .data_o(dob));

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(input int w, input int n);
    int l, m, j, mi, k, idx;
    longint acc;
    logic signed [15:0] r;
    l = w ? 2 : 3;
    m = w ? 5 : 2;
    j = n * m; mi = j / l; k = j % l;
    acc = 0;
    for (int i = 0; k + i*l < 7; i++) begin
      idx = mi - i;
      if (idx >= 0) acc += longint'(hc[k + i*l]) * longint'(w ? xb[idx] : xa[idx]);
    end
    r = 16'(acc >>> 16);
    return int'(r);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (va && ra && nia < 256) begin xa[nia] = int'($signed(da)); nia++; end
      if (vb && rb && nib < 256) begin xb[nib] = int'($signed(db)); nib++; end
      if (voa && noa < 256) begin
        check("R2 R3 value A", int'($signed(doa)), model(0, noa));
        oa[noa] = int'($signed(doa));
        if (vcnt == 0) vfirst = cyc;
        vlast = cyc; vcnt++; noa++;
      end
      if (vob && nob < 256) begin
        check("R9 value B", int'($signed(dob)), model(1, nob));
        nob++;
      end
    end
  end

  always @(posedge clk) if (toggle_en) #2 qa = ~qa;

  task automatic do_reset();
    rst_n = 1'b0; va = 0; vb = 0; qa = 0; qb = 0; da = '0; db = '0;
    toggle_en = 1'b0;
    repeat (3) @(posedge clk);
    nia = 0; nib = 0; noa = 0; nob = 0; vcnt = 0;
    #1 rst_n = 1'b1;
  endtask

  task automatic push_a(input int v);
    va = 1'b1; da = 16'(v);
    do @(negedge clk); while (!ra);
    @(posedge clk); #1 va = 1'b0;
  endtask

  task automatic push_b(input int v);
    vb = 1'b1; db = 16'(v);
    do @(negedge clk); while (!rb);
    @(posedge clk); #1 vb = 1'b0;
  endtask

  task automatic t_reset();
    int seen;
    do_reset();
    @(negedge clk);
    check("R1 valid_o after reset", int'(voa), 0);
    check("R1 ready_o after reset", int'(ra), 1);
    qa = 1'b1; seen = 0;
    repeat (6) begin @(negedge clk); seen += int'(voa); end
    check("R4 no output without input", seen, 0);
  endtask

  task automatic t_latency();
    do_reset();
    @(posedge clk); #1 qa = 1'b1; va = 1'b1; da = 16'd1000;
    @(negedge clk); check("R8 ready on C", int'(ra), 1);
    @(posedge clk); #1 va = 1'b0;
    @(negedge clk); check("R8 no output on C+1", int'(voa), 0);
    @(negedge clk); check("R8 output on C+2", int'(voa), 1);
    check("R1 first output uses only x0", int'($signed(doa)), 18);
  endtask

  task automatic t_floor();
    do_reset();
    qa = 1'b1;
    push_a(-1);
    repeat (6) @(negedge clk);
    check("R3 floor of negative", oa[0], -1);
    do_reset();
    qa = 1'b1;
    push_a(30000);
    repeat (6) @(negedge clk);
    check("R3 floor of positive", oa[0], 549);
  endtask

  task automatic t_stream();
    do_reset();
    qa = 1'b1;
    for (int i = 0; i < 40; i++) push_a(((i * 7919) % 60001) - 30000);
    repeat (20) @(negedge clk);
    check("R7 output count", vcnt, 60);
    check("R7 no gaps", vlast - vfirst + 1, vcnt);
  endtask

  task automatic t_backpress();
    int bad_r, bad_v;
    do_reset();
    qa = 1'b0;
    push_a(2500);
    va = 1'b1; da = 16'sd12345;
    bad_r = 0; bad_v = 0;
    repeat (6) begin @(negedge clk); bad_r += int'(ra); bad_v += int'(voa); end
    check("R5 ready low while held", bad_r, 0);
    check("R4 valid low without req", bad_v, 0);
    check("R6 junk not taken", nia, 1);
    @(posedge clk); #1 qa = 1'b1;
    push_a(-7000);
    toggle_en = 1'b1;
    for (int i = 2; i < 10; i++) push_a((i * 3001) - 14000);
    toggle_en = 1'b0;
    @(posedge clk); #3 qa = 1'b1;
    repeat (30) @(negedge clk);
    check("R5 output count", noa, 15);
  endtask

  task automatic t_decim();
    do_reset();
    qb = 1'b1;
    for (int i = 0; i < 20; i++) push_b((i * 4099) % 50000 - 25000);
    repeat (20) @(negedge clk);
    check("R9 output count", nob, 8);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_floor();
    t_stream();
    t_backpress();
    t_decim();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule